// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block turns a window of instruction bytes into the fields of one instruction and the address of the instruction after it. The encoding packs each instruction into one, two, five or six bytes. The first byte holds an instruction class and a function selector. An optional second byte holds two register specifiers. An optional four-byte little-endian constant follows. Which optional parts are present depends only on the instruction class, so the length is known from the first byte alone.

A registered wrapper keeps the program counter. It presents the counter on `pc`, and the surrounding memory returns the six bytes starting at that address on `fetch_window`. The wrapper decodes one instruction per cycle and moves the counter to the next sequential address. It stops for good on a halt and holds in place on an invalid code. Branch resolution, execution and register storage belong to other blocks.

Top module: `ifetch_core`

## Requirements
- R1: `icode` equals bits 7:4 and `ifun` equals bits 3:0 of window byte 0. Window byte k sits on `fetch_window[8k+7:8k]` and is the byte at address pc+k.
- R2: Classes 2, 3, 4, 5, 6, 0xA and 0xB carry a register byte (window byte 1), with `ra` = its bits 7:4 and `rb` = its bits 3:0. Classes 0, 1, 7, 8 and 9 have no register byte, and then both `ra` and `rb` read 0xF.
- R3: Classes 3, 4 and 5 take `valc` from window bytes 2..5, and classes 7 and 8 take it from bytes 1..4. In both cases the lowest-addressed byte is the least significant. All other classes give `valc` = 0.
- R4: For a valid instruction, `valp` = pc + 1 for classes 0, 1 and 9; pc + 2 for classes 2, 6, 0xA and 0xB; pc + 5 for classes 7 and 8; pc + 6 for classes 3, 4 and 5.
- R5: `instr_valid` is low when the class is above 0xB. It is also low when the function code is out of range: above 6 for classes 2 and 7, above 3 for class 6, and nonzero for every other class.
- R6: While `rst` is high at a rising edge, `pc` becomes 0 and `halted` becomes 0.
- R7: After reset, on each rising edge with a valid, non-halt instruction decoded and `halted` low, `pc` takes the value `valp` had before the edge.
- R8: A valid halt (class 0) decoded at an edge sets `halted`. From then on `pc` stays at the halt address, and `halted` stays high until reset.
- R9: An invalid instruction leaves `pc` unchanged at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| fetch_window | input | 48 | Six instruction bytes starting at `pc`, byte 0 in the low bits |
| pc | output | 32 | Address of the instruction being decoded |
| icode | output | 4 | Instruction class |
| ifun | output | 4 | Function selector |
| ra | output | 4 | First register specifier, 0xF when absent |
| rb | output | 4 | Second register specifier, 0xF when absent |
| valc | output | 32 | Little-endian constant, 0 when absent |
| valp | output | 32 | Address of the next sequential instruction |
| instr_valid | output | 1 | Class and function code are legal |
| halted | output | 1 | A halt has been decoded since reset |

## Verification
The main stream walks through every instruction class in turn. Each class uses different register nibbles and different constant bytes, so a swapped nibble, a byte taken at the wrong offset or a wrong length shows up on the fields and on the next counter value. A second stream puts function codes at and just past the legal limit for each class, followed by a class above 0xB. This separates the valid cases from the invalid ones and checks that the counter holds on an invalid code. Further runs start directly on a halt and place a halt at the end of the stream. These confirm that the counter freezes at the halt address and that only reset releases it.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

    typedef enum logic [3:0] {
        OP_HALT  = 4'h0,
        OP_NOP   = 4'h1,
        OP_RRMOV = 4'h2,
        OP_IRMOV = 4'h3,
        OP_RMMOV = 4'h4,
        OP_MRMOV = 4'h5,
        OP_ALU   = 4'h6,
        OP_JUMP  = 4'h7,
        OP_CALL  = 4'h8,
        OP_RET   = 4'h9,
        OP_PUSH  = 4'hA,
        OP_POP   = 4'hB
    } opcode_e;

    localparam logic [3:0] NO_REG     = 4'hF;
    localparam logic [3:0] MAX_COND   = 4'h6;
    localparam logic [3:0] MAX_ALUFN  = 4'h3;

    typedef struct packed {
        logic [3:0] code;
        logic [3:0] fn;
        logic       legal;
        logic       has_reg;
        logic       has_const;
    } head_t;

    function automatic logic code_has_reg(input logic [3:0] c);
        case (c)
            OP_RRMOV, OP_IRMOV, OP_RMMOV, OP_MRMOV,
            OP_ALU, OP_PUSH, OP_POP: code_has_reg = 1'b1;
            default:                 code_has_reg = 1'b0;
        endcase
    endfunction

    function automatic logic code_has_const(input logic [3:0] c);
        case (c)
            OP_IRMOV, OP_RMMOV, OP_MRMOV,
            OP_JUMP, OP_CALL: code_has_const = 1'b1;
            default:          code_has_const = 1'b0;
        endcase
    endfunction

    function automatic logic fn_legal(input logic [3:0] c, input logic [3:0] f);
        if (c > OP_POP)
            fn_legal = 1'b0;
        else if (c == OP_RRMOV || c == OP_JUMP)
            fn_legal = (f <= MAX_COND);
        else if (c == OP_ALU)
            fn_legal = (f <= MAX_ALUFN);
        else
            fn_legal = (f == 4'h0);
    endfunction

endpackage

// File: rtl/ifd_opsplit.sv
module ifd_opsplit
    import ifetch_pkg::*;
(
    input  logic [7:0] byte0,
    output head_t      head
);
    always_comb begin
        head.code      = byte0[7:4];
        head.fn        = byte0[3:0];
        head.legal     = fn_legal(byte0[7:4], byte0[3:0]);
        head.has_reg   = code_has_reg(byte0[7:4]);
        head.has_const = code_has_const(byte0[7:4]);
    end
endmodule

// File: rtl/ifd_fields.sv
module ifd_fields
    import ifetch_pkg::*;
#(
    parameter int WORD_BYTES = 4
) (
    input  logic [8*(WORD_BYTES+2)-1:0] window,
    input  logic                        has_reg,
    input  logic                        has_const,
    output logic [3:0]                  ra,
    output logic [3:0]                  rb,
    output logic [8*WORD_BYTES-1:0]     valc
);
    localparam int CONST_W = 8 * WORD_BYTES;

    logic [CONST_W-1:0] const_raw;

    // Constant starts one byte later when a register byte is present.
    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_cbyte
        assign const_raw[8*k +: 8] = has_reg ? window[8*(k+2) +: 8]
                                             : window[8*(k+1) +: 8];
    end

    always_comb begin
        ra   = has_reg ? window[15:12] : NO_REG;
        rb   = has_reg ? window[11:8]  : NO_REG;
        valc = has_const ? const_raw : '0;
    end
endmodule

// File: rtl/ifd_nextpc.sv
module ifd_nextpc #(
    parameter int PC_W       = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic [PC_W-1:0] pc,
    input  logic            has_reg,
    input  logic            has_const,
    output logic [PC_W-1:0] valp
);
    localparam logic [PC_W-1:0] STEP_CONST = PC_W'(WORD_BYTES);

    always_comb begin
        valp = pc + PC_W'(1) + PC_W'(has_reg) + (has_const ? STEP_CONST : '0);
    end
endmodule

// File: rtl/ifetch_core.sv
module ifetch_core
    import ifetch_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int WORD_BYTES = 4,
    localparam int WIN_BYTES = WORD_BYTES + 2,
    localparam int CONST_W   = 8 * WORD_BYTES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [8*WIN_BYTES-1:0] fetch_window,
    output logic [PC_W-1:0]        pc,
    output logic [3:0]             icode,
    output logic [3:0]             ifun,
    output logic [3:0]             ra,
    output logic [3:0]             rb,
    output logic [CONST_W-1:0]     valc,
    output logic [PC_W-1:0]        valp,
    output logic                   instr_valid,
    output logic                   halted
);
    head_t head;
    logic  advance;
    logic  stop_now;

    ifd_opsplit u_split (
        .byte0 (fetch_window[7:0]),
        .head  (head)
    );

    ifd_fields #(.WORD_BYTES(WORD_BYTES)) u_fields (
        .window    (fetch_window),
        .has_reg   (head.has_reg),
        .has_const (head.has_const),
        .ra        (ra),
        .rb        (rb),
        .valc      (valc)
    );

    ifd_nextpc #(.PC_W(PC_W), .WORD_BYTES(WORD_BYTES)) u_next (
        .pc        (pc),
        .has_reg   (head.has_reg),
        .has_const (head.has_const),
        .valp      (valp)
    );

    assign icode       = head.code;
    assign ifun        = head.fn;
    assign instr_valid = head.legal;
    assign stop_now    = head.legal && (head.code == OP_HALT);
    assign advance     = head.legal && !stop_now && !halted;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            halted <= 1'b0;
        end else begin
            if (advance)
                pc <= valp;
            if (stop_now)
                halted <= 1'b1;
        end
    end

    AST_RESET_PC: assert property (@(posedge clk)
        rst |=> (pc == '0 && !halted));                                        // R6

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && icode != 4'h0 && !halted) |=> pc == $past(valp));     // R7

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc)));                                   // R8

    AST_INVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(pc));                                         // R9

    AST_NOREG_F: assert property (@(posedge clk) disable iff (rst)
        (icode inside {4'h0, 4'h1, 4'h7, 4'h8, 4'h9}) |-> (ra == 4'hF && rb == 4'hF)); // R2

    AST_LEN_SET: assert property (@(posedge clk) disable iff (rst)
        instr_valid |-> ((valp - pc) inside {PC_W'(1), PC_W'(2), PC_W'(5), PC_W'(6)})); // R4

endmodule

// File: tb/ifetch_core_tb.sv
module ifetch_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [47:0] fetch_window = '0;
    logic [31:0] pc, valc, valp;
    logic [3:0]  icode, ifun, ra, rb;
    logic        instr_valid, halted;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] mem [0:255];
    logic [31:0] pc_m;
    logic        halted_m;

    always #10 clk = ~clk;   // 50 MHz

    ifetch_core u_dut (
        .clk(clk), .rst(rst), .fetch_window(fetch_window),
        .pc(pc), .icode(icode), .ifun(ifun), .ra(ra), .rb(rb),
        .valc(valc), .valp(valp), .instr_valid(instr_valid), .halted(halted)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    endtask

    // Reference decode: lengths and legality written as a table of cases.
    task automatic ref_step();
        int op, fn, len, cofs;
        bit ok, regb;
        logic [31:0] c_exp;
        // R6 R7 R8 R9: counter and halt flag against the model
        check("R7", "pc", pc, pc_m);
        check("R8", "halted", {31'd0, halted}, {31'd0, halted_m});
        for (int k = 0; k < 6; k++)
            fetch_window[8*k +: 8] = mem[(pc_m + k) % 256];
        #1;
        op = mem[pc_m % 256] >> 4;
        fn = mem[pc_m % 256] & 15;
        case (op)
            0, 1, 9:   begin len = 1; ok = (fn == 0); end
            2:         begin len = 2; ok = (fn <= 6); end
            6:         begin len = 2; ok = (fn <= 3); end
            10, 11:    begin len = 2; ok = (fn == 0); end
            7:         begin len = 5; ok = (fn <= 6); end
            8:         begin len = 5; ok = (fn == 0); end
            3, 4, 5:   begin len = 6; ok = (fn == 0); end
            default:   begin len = 1; ok = 0; end
        endcase
        regb = (len == 2 || len == 6);
        cofs = (len == 6) ? 2 : 1;
        c_exp = 32'd0;
        if (len >= 5)
            for (int k = 3; k >= 0; k--)
                c_exp = (c_exp << 8) | 32'(mem[(pc_m + cofs + k) % 256]);
        check("R1", "icode", {28'd0, icode}, 32'(op));
        check("R1", "ifun", {28'd0, ifun}, 32'(fn));
        check("R5", "instr_valid", {31'd0, instr_valid}, {31'd0, ok});
        if (ok) begin
            check("R2", "ra", {28'd0, ra}, regb ? 32'(mem[(pc_m + 1) % 256] >> 4) : 32'hF);
            check("R2", "rb", {28'd0, rb}, regb ? 32'(mem[(pc_m + 1) % 256] & 15) : 32'hF);
            check("R3", "valc", valc, c_exp);
            check("R4", "valp", valp, pc_m + 32'(len));
            if (op == 0) halted_m = 1'b1;
            else if (!halted_m) pc_m = pc_m + 32'(len);
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        // R6: reset state
        check("R6", "pc after reset", pc, 32'd0);
        check("R6", "halted after reset", {31'd0, halted}, 32'd0);
        rst = 1'b0;
        pc_m = 32'd0;
        halted_m = 1'b0;
    endtask

    task automatic run(input int cycles);
        for (int i = 0; i < cycles; i++) ref_step();
    endtask

    task automatic put(input int addr, input logic [7:0] b);
        mem[addr % 256] = b;
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int a;
        // Stream 1: every class once, then halt (R1 R2 R3 R4 R7 R8)
        clear_mem();
        a = 0;
        put(a, 8'h30); put(a+1, 8'hF3); put(a+2, 8'h78); put(a+3, 8'h56); put(a+4, 8'h34); put(a+5, 8'h12); a += 6;
        put(a, 8'h20); put(a+1, 8'h23); a += 2;
        put(a, 8'h61); put(a+1, 8'h12); a += 2;
        put(a, 8'h73); put(a+1, 8'hEF); put(a+2, 8'hBE); put(a+3, 8'hAD); put(a+4, 8'hDE); a += 5;
        put(a, 8'h80); put(a+1, 8'h11); put(a+2, 8'h22); put(a+3, 8'h33); put(a+4, 8'h44); a += 5;
        put(a, 8'h90); a += 1;
        put(a, 8'h10); a += 1;
        put(a, 8'hA0); put(a+1, 8'h4F); a += 2;
        put(a, 8'hB0); put(a+1, 8'h5F); a += 2;
        put(a, 8'h40); put(a+1, 8'h12); put(a+2, 8'h01); put(a+3, 8'h02); put(a+4, 8'h03); put(a+5, 8'h04); a += 6;
        put(a, 8'h50); put(a+1, 8'h34); put(a+2, 8'hA5); put(a+3, 8'h5A); put(a+4, 8'hC3); put(a+5, 8'h3C); a += 6;
        put(a, 8'h26); put(a+1, 8'h01); a += 2;
        put(a, 8'h00);
        @(negedge clk);
        do_reset();
        run(18);

        // Stream 2: function-code limits, then illegal code holds (R5 R9)
        clear_mem();
        put(0, 8'h63); put(1, 8'h01);
        put(2, 8'h76); put(3, 8'h10); put(4, 8'h20); put(5, 8'h30); put(6, 8'h40);
        put(7, 8'h26); put(8, 8'h45);
        put(9, 8'h64); put(10, 8'h01);
        do_reset();
        run(8);
        put(9, 8'h27);
        run(3);
        put(9, 8'h11);
        run(3);
        put(9, 8'hC0);
        run(3);
        put(9, 8'h10); put(10, 8'h00);
        run(4);

        // Stream 3: halt at address 0, then reset releases (R6 R8)
        clear_mem();
        do_reset();
        run(5);
        put(0, 8'h10); put(1, 8'h10); put(2, 8'h00);
        do_reset();
        run(6);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule